// File: doc/BRIEF.md
# Multi-Mode Display Host Bus Front End

This block is the host-facing slave port of a display controller. A host processor writes command words and pixel words through it, and can read status or pixel data, using one of six bus styles. Three static select pins choose the style: Intel-style strobe parallel (8 or 16 bits wide), Motorola-style enable parallel (8 or 16 bits wide), 4-wire 8-bit serial, or 3-wire 9-bit serial. Whatever the style, the block turns every completed host transfer into one uniform internal write beat. Each beat carries a 16-bit word, a flag that tells display data from a command word, and a one-cycle valid pulse.

All host strobes, the select line, the serial clock and serial data pass through a two-flop synchroniser into the system clock. The parallel data bus passes through a matching two-stage delay, so that the word taken at a detected edge is the word that was on the pins when the strobe moved. Parallel reads raise a one-cycle read request toward the core. The block presents the core's response word on its output bus and asserts the tri-state enable for the whole read phase. In the serial styles the register-select pad acts as the serial clock.

Top module: `disp_host_if`

## Requirements
- R1: `if_sel` selects the bus style: 111 Intel 16-bit, 110 Intel 8-bit, 101 Motorola 16-bit, 100 Motorola 8-bit, 011 4-wire serial, 010 3-wire serial. Codes 000 and 001 produce no write beat, no read request and no bus drive.
- R2: No transfer is accepted while `cs_n` is high, and `bus_oe` is low whenever `cs_n` has been high for three clocks.
- R3: In the Intel styles, a rising edge on `rw_wrn` while selected yields one write beat. Its word is the `bus_in` value present at that edge, and `wr_is_data` equals `rs_scl` (1 = display data, 0 = command).
- R4: In the Intel styles, a falling edge on `e_rdn` while selected yields one `rd_req` pulse. `bus_oe` stays high while `e_rdn` is low, and `bus_out` carries `rd_data_i`.
- R5: In the Motorola styles, with `rw_wrn` low, a falling edge on `e_rdn` yields one write beat carrying `bus_in`, with the flag taken from `rs_scl`.
- R6: In the Motorola styles, with `rw_wrn` high, a rising edge on `e_rdn` yields one `rd_req` pulse. `bus_oe` stays high while `e_rdn` is high.
- R7: In the 8-bit parallel styles, `bus_in[15:8]` is ignored and `wr_data[15:8]` is 0 on writes. On reads, `bus_out[15:8]` is driven as 0.
- R8: In 3-wire serial, nine bits are shifted in MSB first on rising `rs_scl` edges. The first bit is the flag, and the remaining eight bits form `wr_data[7:0]` (upper bits 0).
- R9: In 4-wire serial, eight bits are shifted in MSB first, and `dc_sel` is sampled with the eighth bit as the flag. Raising `cs_n` mid-frame discards the partial frame.
- R10: In the serial styles, `rw_wrn` and `e_rdn` have no effect, and neither `bus_oe` nor `rd_req` is ever asserted.
- R11: Every completed transfer raises `wr_valid` for exactly one clock, within four clocks of the host edge.
- R12: While `rst_n` is low, `wr_valid`, `rd_req`, `bus_oe`, `wr_data` and `bus_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| if_sel | input | 3 | Static bus-style select |
| cs_n | input | 1 | Active-low chip select |
| rs_scl | input | 1 | Data/command select (parallel) or serial clock (serial) |
| rw_wrn | input | 1 | Intel write strobe (active low) or Motorola read/write level |
| e_rdn | input | 1 | Intel read strobe (active low) or Motorola enable |
| sdi | input | 1 | Serial data in |
| dc_sel | input | 1 | Data/command line for 4-wire serial |
| bus_in | input | 16 | Parallel data bus, input side |
| bus_out | output | 16 | Parallel data bus, output side |
| bus_oe | output | 1 | Tri-state enable for `bus_out` |
| rd_data_i | input | 16 | Read response word from the core |
| rd_req | output | 1 | One-cycle read request to the core |
| wr_valid | output | 1 | One-cycle write beat valid |
| wr_is_data | output | 1 | Beat flag: 1 display data, 0 command |
| wr_data | output | 16 | Beat word |

## Verification
On every cycle, the assertions check that valid and read-request pulses last one clock and that narrow styles never emit upper-byte bits. They also check that the serial bit counter stays within its frame, and that the serial and unused select codes never drive the bus or request a read. Only the bench scenarios can show the rest. That includes:
- the word and flag latched on the correct strobe edge for each of the four parallel styles;
- MSB-first assembly of the 9-bit and 8-bit serial frames;
- discarding of a frame cut short by chip select;
- the absence of any effect from the read/write pins in serial styles.

// File: rtl/dhi_pkg.sv
package dhi_pkg;

    localparam int unsigned DW = 16;
    localparam int unsigned BW = 8;

    typedef enum logic [2:0] {
        MODE_OFF0 = 3'b000,
        MODE_OFF1 = 3'b001,
        MODE_S3W  = 3'b010,
        MODE_S4W  = 3'b011,
        MODE_M8   = 3'b100,
        MODE_M16  = 3'b101,
        MODE_I8   = 3'b110,
        MODE_I16  = 3'b111
    } bus_mode_e;

    typedef struct packed {
        logic          vld;
        logic          flag;
        logic [DW-1:0] data;
    } wbeat_t;

    function automatic logic mode_intel(input logic [2:0] m);
        return (bus_mode_e'(m) == MODE_I8) || (bus_mode_e'(m) == MODE_I16);
    endfunction

    function automatic logic mode_moto(input logic [2:0] m);
        return (bus_mode_e'(m) == MODE_M8) || (bus_mode_e'(m) == MODE_M16);
    endfunction

    function automatic logic mode_wide(input logic [2:0] m);
        return (bus_mode_e'(m) == MODE_I16) || (bus_mode_e'(m) == MODE_M16);
    endfunction

    function automatic logic mode_s3(input logic [2:0] m);
        return bus_mode_e'(m) == MODE_S3W;
    endfunction

    function automatic logic mode_s4(input logic [2:0] m);
        return bus_mode_e'(m) == MODE_S4W;
    endfunction

endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
    parameter int unsigned    W   = 1,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = din;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{st1: RST, st2: RST};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.st2;

endmodule

// File: rtl/dhi_par.sv
module dhi_par
    import dhi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          cs_n_s,
    input  logic          rs_s,
    input  logic          rw_s,
    input  logic          e_s,
    input  logic [DW-1:0] bus_s,
    input  logic [DW-1:0] rd_data_i,
    output wbeat_t        beat,
    output logic          rd_req,
    output logic          oe,
    output logic [DW-1:0] dout
);

    typedef struct packed {
        logic          prev_rw;
        logic          prev_e;
        wbeat_t        wb;
        logic          rd_req;
        logic          oe;
        logic [DW-1:0] dout;
    } par_st_t;

    par_st_t par_d, par_q;
    logic    wr_ev, rd_ev, drive;
    logic    wide;

    always_comb begin
        wide         = mode_wide(mode);
        par_d        = par_q;
        par_d.prev_rw = rw_s;
        par_d.prev_e  = e_s;
        par_d.wb.vld  = 1'b0;
        wr_ev = 1'b0;
        rd_ev = 1'b0;
        drive = 1'b0;
        if (mode_intel(mode)) begin
            // write strobe rises, read strobe falls
            wr_ev = !cs_n_s && rw_s && !par_q.prev_rw;
            rd_ev = !cs_n_s && !e_s && par_q.prev_e;
            drive = !cs_n_s && !e_s;
        end else if (mode_moto(mode)) begin
            // enable falls with write level, rises with read level
            wr_ev = !cs_n_s && !rw_s && !e_s && par_q.prev_e;
            rd_ev = !cs_n_s && rw_s && e_s && !par_q.prev_e;
            drive = !cs_n_s && rw_s && e_s;
        end
        if (wr_ev) begin
            par_d.wb.vld  = 1'b1;
            par_d.wb.flag = rs_s;
            par_d.wb.data = wide ? bus_s : {{(DW-BW){1'b0}}, bus_s[BW-1:0]};
        end
        par_d.rd_req = rd_ev;
        par_d.oe     = drive;
        par_d.dout   = wide ? rd_data_i : {{(DW-BW){1'b0}}, rd_data_i[BW-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q         <= '0;
            par_q.prev_rw <= 1'b1;
            par_q.prev_e  <= 1'b1;
        end else begin
            par_q <= par_d;
        end
    end

    assign beat   = par_q.wb;
    assign rd_req = par_q.rd_req;
    assign oe     = par_q.oe;
    assign dout   = par_q.dout;

    // R7: narrow styles never deliver upper-byte bits
    a_r7_narrow_write_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (par_q.wb.vld && !mode[0]) |-> (par_q.wb.data[DW-1:BW] == '0));

    a_r7_narrow_read_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (par_q.oe && !mode[0]) |-> (par_q.dout[DW-1:BW] == '0));

    // R4: a read request lasts a single clock
    a_r4_rdreq_single: assert property (@(posedge clk) disable iff (!rst_n)
        par_q.rd_req |=> !par_q.rd_req);

    // R11: a parallel write beat lasts a single clock
    a_r11_par_single: assert property (@(posedge clk) disable iff (!rst_n)
        par_q.wb.vld |=> !par_q.wb.vld);

endmodule

// File: rtl/dhi_ser.sv
module dhi_ser
    import dhi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       cs_n_s,
    input  logic       scl_s,
    input  logic       sdi_s,
    input  logic       dc_s,
    output wbeat_t     beat
);

    localparam int unsigned F3 = BW + 1;
    localparam int unsigned CW = $clog2(F3 + 1);
    localparam logic [CW-1:0] LAST3 = CW'(F3 - 1);
    localparam logic [CW-1:0] LAST4 = CW'(BW - 1);

    typedef struct packed {
        logic          prev_scl;
        logic [CW-1:0] cnt;
        logic [F3-1:0] sh;
        wbeat_t        wb;
    } ser_st_t;

    ser_st_t       ser_d, ser_q;
    logic [F3-1:0] nsh;
    logic          rise, last, s3, s4;

    always_comb begin
        s3           = mode_s3(mode);
        s4           = mode_s4(mode);
        ser_d        = ser_q;
        ser_d.prev_scl = scl_s;
        ser_d.wb.vld   = 1'b0;
        rise = scl_s && !ser_q.prev_scl && !cs_n_s && (s3 || s4);
        nsh  = {ser_q.sh[F3-2:0], sdi_s};
        last = s3 ? (ser_q.cnt == LAST3) : (ser_q.cnt == LAST4);
        if (cs_n_s) begin
            // deselect drops any partial frame
            ser_d.cnt = '0;
            ser_d.sh  = '0;
        end else if (rise) begin
            ser_d.sh = nsh;
            if (last) begin
                ser_d.cnt     = '0;
                ser_d.wb.vld  = 1'b1;
                ser_d.wb.flag = s3 ? nsh[F3-1] : dc_s;
                ser_d.wb.data = {{(DW-BW){1'b0}}, nsh[BW-1:0]};
            end else begin
                ser_d.cnt = ser_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign beat = ser_q.wb;

    // R8: bit counter never leaves a 9-bit frame
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ser_q.cnt <= LAST3);

    // R9: in 4-wire style the counter never passes the eighth bit
    a_r9_s4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s4 |-> (ser_q.cnt <= LAST4));

    // R11: a serial beat lasts a single clock
    a_r11_ser_single: assert property (@(posedge clk) disable iff (!rst_n)
        ser_q.wb.vld |=> !ser_q.wb.vld);

endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
    import dhi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    if_sel,
    input  logic          cs_n,
    input  logic          rs_scl,
    input  logic          rw_wrn,
    input  logic          e_rdn,
    input  logic          sdi,
    input  logic          dc_sel,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [DW-1:0] rd_data_i,
    output logic          rd_req,
    output logic          wr_valid,
    output logic          wr_is_data,
    output logic [DW-1:0] wr_data
);

    localparam int unsigned NCTL = 6;
    // order: dc, sdi, e/rd, rw/wr, rs/scl, cs
    localparam logic [NCTL-1:0] CTL_RST = 6'b001101;

    logic [NCTL-1:0] ctl_s;
    logic [DW-1:0]   bus_s;
    wbeat_t          par_beat, ser_beat;
    logic            par_oe, par_rd;
    logic [DW-1:0]   par_dout;

    dhi_sync #(.W(NCTL), .RST(CTL_RST)) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({dc_sel, sdi, e_rdn, rw_wrn, rs_scl, cs_n}),
        .dout (ctl_s)
    );

    // data bus delayed to stay aligned with the synchronised strobes
    dhi_sync #(.W(DW), .RST('0)) u_bus_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_in),
        .dout (bus_s)
    );

    dhi_par u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (if_sel),
        .cs_n_s   (ctl_s[0]),
        .rs_s     (ctl_s[1]),
        .rw_s     (ctl_s[2]),
        .e_s      (ctl_s[3]),
        .bus_s    (bus_s),
        .rd_data_i(rd_data_i),
        .beat     (par_beat),
        .rd_req   (par_rd),
        .oe       (par_oe),
        .dout     (par_dout)
    );

    dhi_ser u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (if_sel),
        .cs_n_s(ctl_s[0]),
        .scl_s (ctl_s[1]),
        .sdi_s (ctl_s[4]),
        .dc_s  (ctl_s[5]),
        .beat  (ser_beat)
    );

    always_comb begin
        wr_valid   = par_beat.vld | ser_beat.vld;
        wr_is_data = par_beat.vld ? par_beat.flag : (ser_beat.vld & ser_beat.flag);
        wr_data    = par_beat.vld ? par_beat.data : (ser_beat.vld ? ser_beat.data : '0);
        bus_oe     = par_oe;
        rd_req     = par_rd;
        bus_out    = par_oe ? par_dout : '0;
    end

    // R10: serial styles never drive the bus nor request reads
    a_r10_serial_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_sel[2] && if_sel[1]) |-> (!bus_oe && !rd_req));

    // R1: unused select codes stay completely quiet
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (if_sel[2:1] == 2'b00) |-> (!wr_valid && !bus_oe && !rd_req));

    // R11: merged beat stream pulses for one clock
    a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

endmodule

// File: tb/disp_host_if_tb_top.sv
module disp_host_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  if_sel = 3'b111;
    logic        cs_n = 1'b1;
    logic        rs_scl = 1'b0;
    logic        rw_wrn = 1'b1;
    logic        e_rdn = 1'b1;
    logic        sdi = 1'b0;
    logic        dc_sel = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic [15:0] rd_data_i = 16'hC3A5;
    logic        rd_req;
    logic        wr_valid;
    logic        wr_is_data;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    int rcnt = 0;
    int multi = 0;
    logic        prev_v = 1'b0;
    logic [15:0] last_d = '0;
    logic        last_f = 1'b0;

    always #5 clk = ~clk;

    disp_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .cs_n(cs_n),
        .rs_scl(rs_scl), .rw_wrn(rw_wrn), .e_rdn(e_rdn), .sdi(sdi),
        .dc_sel(dc_sel), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .rd_data_i(rd_data_i), .rd_req(rd_req),
        .wr_valid(wr_valid), .wr_is_data(wr_is_data), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                vcnt   = vcnt + 1;
                last_d = wr_data;
                last_f = wr_is_data;
            end
            if (wr_valid && prev_v) multi = multi + 1;
            if (rd_req) rcnt = rcnt + 1;
        end
        prev_v = wr_valid;
    end

    // mode, rs, bus value, expected word
    localparam logic [35:0] VEC [0:7] = '{
        {3'b111, 1'b1, 16'hA5C3, 16'hA5C3},
        {3'b111, 1'b0, 16'h0123, 16'h0123},
        {3'b110, 1'b1, 16'hBEEF, 16'h00EF},
        {3'b110, 1'b0, 16'hFF10, 16'h0010},
        {3'b101, 1'b1, 16'h1357, 16'h1357},
        {3'b101, 1'b0, 16'h8001, 16'h8001},
        {3'b100, 1'b1, 16'h7F22, 16'h0022},
        {3'b100, 1'b0, 16'hABCD, 16'h00CD}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        cs_n = 1'b1;
        if_sel = m;
        if (m[2:1] == 2'b11) begin rw_wrn = 1'b1; e_rdn = 1'b1; end
        else begin rw_wrn = 1'b1; e_rdn = 1'b0; end
        rs_scl = 1'b0;
        waitc(5);
    endtask

    task automatic par_write(input logic [2:0] m, input logic rs, input logic [15:0] d);
        set_mode(m);
        cs_n = 1'b0; rs_scl = rs; bus_in = d;
        waitc(2);
        if (m[2:1] == 2'b11) begin
            rw_wrn = 1'b0; waitc(4); rw_wrn = 1'b1; waitc(5);
        end else begin
            rw_wrn = 1'b0; e_rdn = 1'b1; waitc(4); e_rdn = 1'b0; waitc(5);
            rw_wrn = 1'b1;
        end
        cs_n = 1'b1; bus_in = '0;
        waitc(4);
    endtask

    task automatic ser_send(input logic [8:0] bits, input int n, input logic dc);
        cs_n = 1'b0; rs_scl = 1'b0;
        waitc(3);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i]; dc_sel = dc; rs_scl = 1'b0; waitc(3);
            rs_scl = 1'b1; waitc(3);
        end
        rs_scl = 1'b0; waitc(5);
        cs_n = 1'b1;
        waitc(4);
    endtask

    task automatic par_read(input logic [2:0] m, input logic [15:0] exp);
        int r0;
        set_mode(m);
        r0 = rcnt;
        cs_n = 1'b0; waitc(2);
        if (m[2:1] == 2'b11) e_rdn = 1'b0;
        else begin rw_wrn = 1'b1; e_rdn = 1'b1; end
        waitc(5);
        chk(m[2:1] == 2'b11 ? "R4 oe during read" : "R6 oe during read", 32'(bus_oe), 32'd1);
        chk("R7 read word", 32'(bus_out), 32'(exp));
        chk(m[2:1] == 2'b11 ? "R4 one rd_req" : "R6 one rd_req", 32'(rcnt - r0), 32'd1);
        if (m[2:1] == 2'b11) e_rdn = 1'b1; else e_rdn = 1'b0;
        waitc(5);
        chk("R2 oe released", 32'(bus_oe), 32'd0);
        cs_n = 1'b1; waitc(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        waitc(4);
        // R12: reset state
        chk("R12 wr_valid in reset", 32'(wr_valid), 0);
        chk("R12 bus_oe in reset", 32'(bus_oe), 0);
        chk("R12 rd_req in reset", 32'(rd_req), 0);
        chk("R12 wr_data in reset", 32'(wr_data), 0);
        chk("R12 bus_out in reset", 32'(bus_out), 0);
        rst_n = 1'b1;
        waitc(4);

        // R3 R5 R7: parallel write table
        for (int k = 0; k < 8; k++) begin
            v0 = vcnt;
            par_write(VEC[k][35:33], VEC[k][32], VEC[k][31:16]);
            chk(VEC[k][35:34] == 2'b11 ? "R3 beat count" : "R5 beat count", 32'(vcnt - v0), 1);
            chk(VEC[k][33] ? "R3/R5 word" : "R7 narrow word", 32'(last_d), 32'(VEC[k][15:0]));
            chk("R3/R5 flag", 32'(last_f), 32'(VEC[k][32]));
        end

        // R4 R6 R7: reads
        par_read(3'b111, 16'hC3A5);
        par_read(3'b110, 16'h00A5);
        par_read(3'b101, 16'hC3A5);
        par_read(3'b100, 16'h00A5);

        // R2: strobe without chip select
        set_mode(3'b111);
        v0 = vcnt;
        bus_in = 16'h5555; rw_wrn = 1'b0; waitc(4); rw_wrn = 1'b1; waitc(6);
        chk("R2 no beat when deselected", 32'(vcnt - v0), 0);

        // R8: 3-wire frames
        set_mode(3'b010);
        v0 = vcnt;
        ser_send({1'b1, 8'h96}, 9, 1'b0);
        chk("R8 beat count", 32'(vcnt - v0), 1);
        chk("R8 word", 32'(last_d), 32'h0096);
        chk("R8 flag", 32'(last_f), 1);
        ser_send({1'b0, 8'h3C}, 9, 1'b1);
        chk("R8 word cmd", 32'(last_d), 32'h003C);
        chk("R8 flag cmd", 32'(last_f), 0);

        // R10: read/write pins ignored in serial
        v0 = vcnt;
        cs_n = 1'b0; waitc(3);
        rw_wrn = 1'b0; e_rdn = 1'b1; waitc(4); e_rdn = 1'b0; waitc(4);
        rw_wrn = 1'b1; e_rdn = 1'b1; waitc(4);
        chk("R10 no beat", 32'(vcnt - v0), 0);
        chk("R10 no oe", 32'(bus_oe), 0);
        e_rdn = 1'b0; waitc(4);
        cs_n = 1'b1; waitc(4);
        ser_send({1'b1, 8'h81}, 9, 1'b0);
        chk("R10 frame intact after pin toggles", 32'(last_d), 32'h0081);

        // R9: 4-wire frames and abort
        set_mode(3'b011);
        v0 = vcnt;
        ser_send({1'b0, 8'hA1}, 8, 1'b1);
        chk("R9 word", 32'(last_d), 32'h00A1);
        chk("R9 dc flag", 32'(last_f), 1);
        v0 = vcnt;
        ser_send({4'b0, 5'b10110}, 5, 1'b1);
        chk("R9 partial discarded", 32'(vcnt - v0), 0);
        ser_send({1'b0, 8'h5A}, 8, 1'b0);
        chk("R9 full after abort count", 32'(vcnt - v0), 1);
        chk("R9 full after abort word", 32'(last_d), 32'h005A);
        chk("R9 cmd flag", 32'(last_f), 0);

        // R1: unused code quiet
        set_mode(3'b001);
        v0 = vcnt;
        cs_n = 1'b0; waitc(2);
        rw_wrn = 1'b0; waitc(4); rw_wrn = 1'b1; waitc(4);
        rs_scl = 1'b1; waitc(3); rs_scl = 1'b0; waitc(5);
        chk("R1 off code no beat", 32'(vcnt - v0), 0);
        chk("R1 off code no oe", 32'(bus_oe), 0);
        cs_n = 1'b1; waitc(4);

        // R12: reset during a partial frame
        set_mode(3'b010);
        cs_n = 1'b0; waitc(3);
        for (int i = 0; i < 4; i++) begin
            sdi = 1'b1; rs_scl = 1'b0; waitc(3); rs_scl = 1'b1; waitc(3);
        end
        rst_n = 1'b0; waitc(2);
        chk("R12 wr_valid under reset", 32'(wr_valid), 0);
        chk("R12 wr_data under reset", 32'(wr_data), 0);
        rs_scl = 1'b0; cs_n = 1'b1; waitc(2);
        rst_n = 1'b1; waitc(4);
        v0 = vcnt;
        ser_send({1'b1, 8'h47}, 9, 1'b0);
        chk("R12 frame after reset", 32'(last_d), 32'h0047);
        chk("R12 one beat after reset", 32'(vcnt - v0), 1);

        // R11: no beat ever lasted two clocks
        chk("R11 single-cycle pulses", 32'(multi), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule